// File: doc/BRIEF.md
# Resonant Half-Cycle Pulse Sequencer

This block runs one current pulse of a series-resonant converter whose single LC tank is shared in time among several terminals. While idle it adds up the magnitudes of the signed per-terminal error values. When that total rises above a programmable trigger level, it asks an external selector for two terminals. It then fires the gate of the first terminal. When the external predictor reports that the crossover point has been reached, it switches the gate to the second terminal. When the resonant current returns to zero, the pulse ends and a programmable turn-off interval starts.

The current direction is held in a register. The selector reads it, so that both chosen terminals conduct in the same direction as the tank current. The register flips after every completed pulse. A pulse with no valid candidate is dropped before any gate fires. A pulse whose crossover or zero-current event does not arrive in time is aborted and flagged.

Top module: `rhc_pulse_seq`

## Requirements
- R1: After reset, `gate` is all zero, `sel_start` is 0, `fault` is 0 and `pulse_dir` is 0.
- R2: While idle, `sel_start` pulses high for exactly one cycle when the sum of error magnitudes is strictly greater than `trig_level`. A sum equal to or below the level starts nothing.
- R3: No gate is driven until the selector answers. The gate is driven from the cycle after `sel_done` with `sel_valid` is sampled. That gate is `gate[sel_first]`, and it stays high for `gate_width` cycles unless it is cut short.
- R4: A sampled `xover` during the first segment ends the first gate and drives `gate[sel_second]` from the next cycle, for `gate_width` cycles or until `izero`.
- R5: At most one bit of `gate` is high in any cycle.
- R6: A sampled `izero` during the second segment clears the gate and inverts `pulse_dir`. Nothing else changes `pulse_dir`.
- R7: After the `izero` that ends a pulse, the next `sel_start` appears no earlier than `toff_cycles`+1 cycles later. For `toff_cycles` ≥ 1 and an error sum already above the level, it appears exactly `toff_cycles`+1 cycles later.
- R8: If `sel_done` arrives with `sel_valid` low, no gate fires, `pulse_dir` is kept, and the block returns to idle. It may request again on the following cycle.
- R9: If `xover` (first segment) or `izero` (second segment) is absent for `timeout_cycles` cycles, the gate drops, `fault` goes to 1 and stays set, `pulse_dir` is kept, and the block goes idle. `fault` clears when the next `sel_start` is issued.
- R10: Each error is a two's-complement field of `ERR_W` bits in `err_vec`, with terminal i at bits [i*ERR_W +: ERR_W]. Its magnitude is used, so negative errors add, and the most negative code adds 2^(ERR_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_vec | input | N_TERM*ERR_W | Packed signed error per terminal |
| trig_level | input | SUM_W | Trigger level for the magnitude sum |
| gate_width | input | CNT_W | Gate pulse length in cycles |
| toff_cycles | input | CNT_W | Turn-off interval in cycles |
| timeout_cycles | input | CNT_W | Watchdog limit per segment in cycles |
| sel_start | output | 1 | One-cycle request to the terminal selector |
| sel_done | input | 1 | Selector finished |
| sel_valid | input | 1 | Selector found a pair of terminals |
| sel_first | input | IDX_W | Index of the first-segment terminal |
| sel_second | input | IDX_W | Index of the second-segment terminal |
| xover | input | 1 | Predictor crossover reached |
| izero | input | 1 | Resonant current has returned to zero |
| pulse_dir | output | 1 | Current direction for this pulse |
| gate | output | N_TERM | One-hot gate drive |
| fault | output | 1 | Watchdog abort flag |

## Verification
The bench builds the block with six terminals, 12-bit errors and 12-bit counters. The most negative error code (-2048) therefore sits right against a 2047 trigger level. The gate width is set to 3 cycles, so crossover and current-zero events can be placed both inside and beyond the gate pulse, giving both truncated and full-length gates. Turn-off values of 4 and 1 make the restart gap exact and measurable. A 20-cycle timeout lets the first-segment watchdog fire within a short run.

// File: rtl/rhc_pulse_seq.sv
module rhc_pulse_seq #(
  parameter int N_TERM = 6,
  parameter int ERR_W  = 12,
  parameter int CNT_W  = 12,
  localparam int IDX_W = $clog2(N_TERM),
  localparam int SUM_W = ERR_W + 1 + $clog2(N_TERM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TERM*ERR_W-1:0] err_vec,
  input  logic [SUM_W-1:0]        trig_level,
  input  logic [CNT_W-1:0]        gate_width,
  input  logic [CNT_W-1:0]        toff_cycles,
  input  logic [CNT_W-1:0]        timeout_cycles,
  output logic                    sel_start,
  input  logic                    sel_done,
  input  logic                    sel_valid,
  input  logic [IDX_W-1:0]        sel_first,
  input  logic [IDX_W-1:0]        sel_second,
  input  logic                    xover,
  input  logic                    izero,
  output logic                    pulse_dir,
  output logic [N_TERM-1:0]       gate,
  output logic                    fault
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_SEL  = 3'd1;
  localparam logic [2:0] S_SEG1 = 3'd2;
  localparam logic [2:0] S_SEG2 = 3'd3;
  localparam logic [2:0] S_TOFF = 3'd4;
  localparam logic [N_TERM-1:0] ONE = 1;

  logic [2:0]       state;
  logic [IDX_W-1:0] gidx, nidx;
  logic [CNT_W-1:0] gcnt, tick;
  logic [SUM_W-1:0] err_sum;
  logic             wd_hit, toff_hit;

  function automatic logic [SUM_W-1:0] mag(input logic [ERR_W-1:0] v);
    logic [ERR_W:0] x;
    x = {v[ERR_W-1], v};
    if (v[ERR_W-1]) x = -x;
    return SUM_W'(x);
  endfunction

  always_comb begin
    err_sum = '0;
    for (int i = 0; i < N_TERM; i++)
      err_sum = err_sum + mag(err_vec[i*ERR_W +: ERR_W]);
  end

  assign wd_hit   = ({1'b0, tick} + 1'b1) >= {1'b0, timeout_cycles};
  assign toff_hit = ({1'b0, tick} + 1'b1) >= {1'b0, toff_cycles};
  assign gate     = (gcnt != '0) ? (ONE << gidx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sel_start <= 1'b0;
      pulse_dir <= 1'b0;
      fault     <= 1'b0;
      gidx      <= '0;
      nidx      <= '0;
      gcnt      <= '0;
      tick      <= '0;
    end else begin
      sel_start <= 1'b0;
      if (gcnt != '0) gcnt <= gcnt - 1'b1;
      case (state)
        S_IDLE:
          if (err_sum > trig_level) begin
            state     <= S_SEL;
            sel_start <= 1'b1;
            fault     <= 1'b0;
          end
        S_SEL:
          if (sel_done) begin
            if (sel_valid) begin
              state <= S_SEG1;
              gidx  <= sel_first;
              nidx  <= sel_second;
              gcnt  <= gate_width;
              tick  <= '0;
            end else begin
              state <= S_IDLE;
            end
          end
        S_SEG1:
          if (xover) begin
            state <= S_SEG2;
            gidx  <= nidx;
            gcnt  <= gate_width;
            tick  <= '0;
          end else if (wd_hit) begin
            state <= S_IDLE;
            fault <= 1'b1;
            gcnt  <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        S_SEG2:
          if (izero) begin
            state     <= S_TOFF;
            gcnt      <= '0;
            pulse_dir <= ~pulse_dir;
            tick      <= '0;
          end else if (wd_hit) begin
            state <= S_IDLE;
            fault <= 1'b1;
            gcnt  <= '0;
          end else begin
            tick <= tick + 1'b1;
          end
        S_TOFF:
          if (toff_hit) state <= S_IDLE;
          else          tick  <= tick + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rhc_pulse_seq_chk.sv
module rhc_pulse_seq_chk #(
  parameter int N_TERM = 6,
  parameter int CNT_W  = 12,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        st,
  input logic              sel_start,
  input logic              sel_done,
  input logic              sel_valid,
  input logic [IDX_W-1:0]  sel_first,
  input logic              xover,
  input logic              izero,
  input logic              pulse_dir,
  input logic [N_TERM-1:0] gate,
  input logic              fault,
  input logic [CNT_W-1:0]  gate_width,
  input logic [CNT_W-1:0]  toff_cycles
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_SEL  = 3'd1;
  localparam logic [2:0] S_SEG1 = 3'd2;
  localparam logic [2:0] S_SEG2 = 3'd3;
  localparam logic [N_TERM-1:0] ONE = 1;

  logic [CNT_W:0] gap;
  logic           end_evt;

  assign end_evt = (st == S_SEG2) && izero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '1;
    else if (end_evt)    gap <= '0;
    else if (gap != '1)  gap <= gap + 1'b1;
  end

  AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate)); // R5
  AST_NO_GATE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEL) |-> (gate == '0)); // R3
  AST_FIRST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEL && sel_done && sel_valid && gate_width != '0) |=> (gate == (ONE << $past(sel_first)))); // R3
  AST_XOVER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEG1 && xover) |=> (st == S_SEG2)); // R4
  AST_DIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (pulse_dir != $past(pulse_dir))); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> $stable(pulse_dir)); // R6
  AST_TOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_start) |-> (gap > {1'b0, toff_cycles})); // R7
  AST_NOCAND_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEL && sel_done && !sel_valid) |=> (gate == '0 && st == S_IDLE)); // R8
  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(st) == S_SEG1 || $past(st) == S_SEG2)); // R9

endmodule

bind rhc_pulse_seq rhc_pulse_seq_chk #(.N_TERM(N_TERM), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .sel_start(sel_start), .sel_done(sel_done),
  .sel_valid(sel_valid), .sel_first(sel_first), .xover(xover), .izero(izero),
  .pulse_dir(pulse_dir), .gate(gate), .fault(fault), .gate_width(gate_width),
  .toff_cycles(toff_cycles)
);

// File: tb/rhc_pulse_seq_test.sv
`timescale 1ns/1ps
module rhc_pulse_seq_test;
  localparam int N_TERM = 6;
  localparam int ERR_W  = 12;
  localparam int CNT_W  = 12;
  localparam int IDX_W  = $clog2(N_TERM);
  localparam int SUM_W  = ERR_W + 1 + $clog2(N_TERM);
  localparam int W      = 3;
  localparam int TMO    = 20;

  typedef struct { logic [N_TERM-1:0] vec; int w; } item_t;

  logic clk = 0, rst_n = 0;
  logic [N_TERM*ERR_W-1:0] err_vec = '0;
  logic [SUM_W-1:0] trig_level = '0;
  logic [CNT_W-1:0] gate_width = '0, toff_cycles = '0, timeout_cycles = '0;
  logic sel_done = 0, sel_valid = 0, xover = 0, izero = 0;
  logic [IDX_W-1:0] sel_first = '0, sel_second = '0;
  logic sel_start, pulse_dir, fault;
  logic [N_TERM-1:0] gate;

  int n_cmp = 0, n_bad = 0, onehot_bad = 0;
  bit exp_dir = 0;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  rhc_pulse_seq #(.N_TERM(N_TERM), .ERR_W(ERR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .trig_level(trig_level),
    .gate_width(gate_width), .toff_cycles(toff_cycles), .timeout_cycles(timeout_cycles),
    .sel_start(sel_start), .sel_done(sel_done), .sel_valid(sel_valid),
    .sel_first(sel_first), .sel_second(sel_second), .xover(xover), .izero(izero),
    .pulse_dir(pulse_dir), .gate(gate), .fault(fault));

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_err(input int i, input int v);
    err_vec[i*ERR_W +: ERR_W] = ERR_W'(v);
  endtask

  task automatic wait_start(output int cyc);
    cyc = 0;
    while (!sel_start && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic answer(input bit valid, input int f, input int s);
    @(negedge clk);
    chk("R2 sel_start single cycle", sel_start == 1'b0, int'(sel_start), 0);
    chk("R3 no gate before selection", gate == '0, int'(gate), 0);
    chk("R6 pulse_dir during select", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));
    sel_valid  = valid;
    sel_first  = IDX_W'(f);
    sel_second = IDX_W'(s);
    sel_done   = 1;
    @(negedge clk);
    sel_done  = 0;
    sel_valid = 0;
  endtask

  task automatic segs(input int k, input int m, input int f, input int s);
    item_t a, b;
    a.vec = N_TERM'(1) << f; a.w = (k < W) ? k : W;
    b.vec = N_TERM'(1) << s; b.w = (m < W) ? m : W;
    exp_q.push_back(a);
    exp_q.push_back(b);
    repeat (k - 1) @(negedge clk);
    xover = 1;
    @(negedge clk);
    xover = 0;
    repeat (m - 1) @(negedge clk);
    izero = 1;
    @(negedge clk);
    izero = 0;
  endtask

  initial begin : monitor
    logic [N_TERM-1:0] prev_g;
    int run;
    item_t it;
    prev_g = '0;
    run = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if ($countones(gate) > 1) onehot_bad++;
        if (gate != prev_g) begin
          if (prev_g != '0) begin
            if (exp_q.size() == 0) begin
              chk("R3 unexpected gate pulse", 1'b0, int'(prev_g), 0);
            end else begin
              it = exp_q.pop_front();
              n_cmp++;
              if (it.vec != prev_g || it.w != run) begin
                n_bad++;
                $display("FAIL R3/R4 gate actual=%b width=%0d expected=%b width=%0d",
                         prev_g, run, it.vec, it.w);
              end
            end
          end
          run = 0;
        end
        if (gate != '0) run++;
        prev_g = gate;
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 1'b0, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    int cyc;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gate after reset", gate == '0, int'(gate), 0);
    chk("R1 sel_start after reset", sel_start == 1'b0, int'(sel_start), 0);
    chk("R1 fault after reset", fault == 1'b0, int'(fault), 0);
    chk("R1 pulse_dir after reset", pulse_dir == 1'b0, int'(pulse_dir), 0);

    gate_width = CNT_W'(W);
    toff_cycles = 4;
    timeout_cycles = CNT_W'(TMO);
    trig_level = 100;

    set_err(0, 60);
    set_err(1, -40);
    seen = 0;
    repeat (8) begin
      @(negedge clk);
      if (sel_start) seen = 1;
    end
    chk("R2 sum equal to level starts nothing", !seen, int'(seen), 0);

    set_err(2, -1);
    wait_start(cyc);
    chk("R10 negative error lifts sum above level", sel_start && cyc <= 2, cyc, 2);

    answer(1, 2, 4);
    segs(2, 5, 2, 4);
    exp_dir ^= 1;
    wait_start(cyc);
    chk("R7 restart gap toff=4", cyc == 5, cyc, 5);
    chk("R6 direction flipped", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));

    answer(1, 0, 5);
    toff_cycles = 1;
    segs(5, 1, 0, 5);
    exp_dir ^= 1;
    wait_start(cyc);
    chk("R7 restart gap toff=1", cyc == 2, cyc, 2);
    chk("R6 direction flipped back", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));

    answer(0, 0, 0);
    wait_start(cyc);
    chk("R8 no-candidate returns to idle and re-requests", cyc == 1, cyc, 1);
    chk("R8 direction kept on no-candidate", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));

    answer(1, 1, 0);
    begin
      item_t a;
      a.vec = N_TERM'(1) << 1;
      a.w = W;
      exp_q.push_back(a);
    end
    err_vec = '0;
    repeat (TMO + 5) @(negedge clk);
    chk("R9 fault after missing crossover", fault == 1'b1, int'(fault), 1);
    chk("R9 gate off after abort", gate == '0, int'(gate), 0);
    chk("R9 direction kept after abort", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));
    chk("R2 no request below level", sel_start == 1'b0, int'(sel_start), 0);

    set_err(3, 500);
    wait_start(cyc);
    chk("R9 fault cleared at next request", sel_start && fault == 1'b0, int'(fault), 0);
    answer(1, 3, 1);
    segs(1, 2, 3, 1);
    exp_dir ^= 1;
    err_vec = '0;
    repeat (5) @(negedge clk);
    chk("R6 direction after short pulse", pulse_dir == exp_dir, int'(pulse_dir), int'(exp_dir));

    trig_level = 2047;
    set_err(4, -2048);
    wait_start(cyc);
    chk("R10 most negative code counts 2048", sel_start == 1'b1, int'(sel_start), 1);
    answer(0, 0, 0);
    err_vec = '0;
    repeat (6) @(negedge clk);

    chk("R5 one-hot gate", onehot_bad == 0, onehot_bad, 0);
    chk("R4 all expected gates seen", exp_q.size() == 0, exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule